// File: doc/BRIEF.md
# Servo Index Detector

This block locates the once-per-revolution index mark in a servo peak stream and produces an index pulse. It runs on a system clock at the sector-clock rate. A divider splits that clock into reference periods of `DIV` cycles and marks the last cycle of each period with a one-cycle strobe. Any peak reported by the level-detect input during a period is latched. At the strobe edge that latched bit enters a short shift register, and the latch is cleared for the next period.

When the six newest register bits equal the programmed index pattern, and the older guard bit holds its expected value, the index output goes high at the next strobe edge. It stays high for exactly one reference period. The strobe and the index pulse are plain level outputs. The peak input is a sampled level with no handshake. No valid/ready interface exists, so back-pressure does not arise.

Top module: `sidx_index_detector`

## Requirements
- R1: With `rst_ni` low at a rising clock edge, the divider, the capture latch, the shift register and the index output are cleared. `index_o` and `ref_stb_o` read 0 after that edge.
- R2: `ref_stb_o` is high for one cycle in every `DIV` cycles. The first strobe falls in the `DIV`-th cycle after reset is released.
- R3: The bit shifted in at a strobe edge is 1 when `peak_i` was high in any cycle of that period, the strobe cycle included. It is 1 only once, however many peaks occur. It is 0 when there was no peak.
- R4: The capture latch is cleared at every strobe edge, so a peak in one period never sets the bit of a later period.
- R5: The shift register takes the newest bit at position 0. A match requires two things. Positions 5..0 must equal `PATTERN`, where `PATTERN` bit 5 is the earliest of the six bits received. When `GUARD_EN` is set, position 6 must also equal `GUARD_BIT`. With the defaults, the pattern is 6'b110101 and the guard bit is 0.
- R6: Suppose the strobe edge completing a match is edge k. Then `index_o` rises at strobe edge k+1 and stays high for exactly `DIV` cycles, unless edge k+1 also completes a match.
- R7: No pulse is produced when any one pattern bit differs or when the guard bit differs.
- R8: `index_o` changes only at strobe edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sector-rate system clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| peak_i | input | 1 | Level-detect servo peak indication, synchronous to `clk_i` |
| ref_stb_o | output | 1 | One-cycle strobe at the end of each reference period |
| index_o | output | 1 | Index pulse, one reference period long |

## Verification
The assertions take for granted that `peak_i` and `rst_ni` are already synchronous to `clk_i` and hold steady around each rising edge. They also take for granted that reset is applied from time zero. The stimulus meets this by changing every input only on the falling clock edge. It then samples outputs a short delay later. Peaks are placed at chosen offsets inside a period, the strobe cycle included, so that each capture case is reached without relying on an asynchronous input.

// File: rtl/sidx_pkg.sv
package sidx_pkg;
  localparam int unsigned DEF_DIV   = 8;
  localparam int unsigned DEF_SR_W  = 7;
  localparam int unsigned DEF_PAT_W = 6;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sidx_ref_div.sv
module sidx_ref_div #(
  parameter int unsigned DIV = sidx_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int unsigned CW = sidx_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);

  // R2: counter never leaves its range
  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R2: strobe is a single-cycle pulse
      a_r2_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_o |=> !stb_o);
    end
  endgenerate
endmodule

// File: rtl/sidx_capture.sv
module sidx_capture #(
  parameter int unsigned SR_W = sidx_pkg::DEF_SR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            peak_i,
  input  logic            stb_i,
  output logic [SR_W-1:0] sr_o
);
  logic            cap_q;
  logic            bit_in;
  logic [SR_W-1:0] sr_q;

  assign bit_in = cap_q | peak_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cap_q <= 1'b0;
    else if (stb_i)  cap_q <= 1'b0;
    else if (peak_i) cap_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    sr_q <= '0;
    else if (stb_i) sr_q <= {sr_q[SR_W-2:0], bit_in};
  end

  assign sr_o = sr_q;

  // R4: latch empty at the start of every period
  a_r4_cap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !cap_q);
  // R3: a peak outside the strobe cycle is held
  a_r3_cap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peak_i && !stb_i) |=> cap_q);
  // R8: register moves only on a boundary
  a_r8_sr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(sr_q));
endmodule

// File: rtl/sidx_match_pulse.sv
module sidx_match_pulse #(
  parameter int unsigned         SR_W      = sidx_pkg::DEF_SR_W,
  parameter int unsigned         PAT_W     = sidx_pkg::DEF_PAT_W,
  parameter logic [PAT_W-1:0]    PATTERN   = 6'b110101,
  parameter bit                  GUARD_EN  = 1'b1,
  parameter bit                  GUARD_BIT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic [SR_W-1:0] sr_i,
  output logic            index_o
);
  logic hit;
  logic index_q;

  generate
    if (GUARD_EN) begin : g_guard
      assign hit = (sr_i[PAT_W-1:0] == PATTERN) && (sr_i[PAT_W] == GUARD_BIT);
    end else begin : g_plain
      assign hit = (sr_i[PAT_W-1:0] == PATTERN);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    index_q <= 1'b0;
    else if (stb_i) index_q <= hit;
  end

  assign index_o = index_q;

  // R8: pulse edges only at boundaries
  a_r8_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(index_q));
  // R6: a rise follows a strobe cycle
  a_r6_rise_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(index_q) |-> $past(stb_i));
endmodule

// File: rtl/sidx_index_detector.sv
module sidx_index_detector #(
  parameter int unsigned      DIV       = sidx_pkg::DEF_DIV,
  parameter int unsigned      SR_W      = sidx_pkg::DEF_SR_W,
  parameter int unsigned      PAT_W     = sidx_pkg::DEF_PAT_W,
  parameter logic [PAT_W-1:0] PATTERN   = 6'b110101,
  parameter bit               GUARD_EN  = 1'b1,
  parameter bit               GUARD_BIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic peak_i,
  output logic ref_stb_o,
  output logic index_o
);
  logic            stb;
  logic [SR_W-1:0] sr;

  sidx_ref_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  sidx_capture #(.SR_W(SR_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .peak_i(peak_i),
    .stb_i (stb),
    .sr_o  (sr)
  );

  sidx_match_pulse #(
    .SR_W(SR_W), .PAT_W(PAT_W), .PATTERN(PATTERN),
    .GUARD_EN(GUARD_EN), .GUARD_BIT(GUARD_BIT)
  ) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb),
    .sr_i   (sr),
    .index_o(index_o)
  );

  assign ref_stb_o = stb;
endmodule

// File: tb/sidx_index_detector_tb_top.sv
`timescale 1ns/1ps
module sidx_index_detector_tb_top;
  localparam logic [5:0] PAT = 6'b110101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic peak = 1'b0;
  logic ref_stb, index;

  int n_run = 0;
  int n_fail = 0;
  logic [6:0] sh = '0;
  logic exp_idx = 1'b0;
  int idx_cycles = 0;

  always #2.5 clk = ~clk;

  sidx_index_detector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .peak_i(peak),
    .ref_stb_o(ref_stb), .index_o(index)
  );

  function automatic logic model_hit(input logic [6:0] s);
    return (s[5:0] == PAT) && (s[6] == 1'b0);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one reference period; called just after a falling edge
  task automatic run_period(input bit b, input int pos, input int pos2, input string tag);
    logic nxt;
    for (int c = 0; c < 8; c++) begin
      peak = b && (c == pos || c == pos2);
      #1;
      chk(ref_stb, (c == 7), {"R2 strobe ", tag});
      chk(index, exp_idx, {"R6 index ", tag});
      if (index === 1'b1) idx_cycles++;
      @(negedge clk);
    end
    peak = 1'b0;
    nxt = model_hit(sh);
    sh = {sh[5:0], b};
    exp_idx = nxt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    peak = 1'b1;
    @(negedge clk);
    #1;
    chk(index, 1'b0, "R1 index in reset");
    chk(ref_stb, 1'b0, "R1 strobe in reset");
    @(negedge clk);
    rst_n = 1'b1;
    peak = 1'b0;
    sh = '0;
    exp_idx = 1'b0;
  endtask

  task automatic send_pattern(input logic [5:0] p, input int pos, input string tag);
    for (int i = 5; i >= 0; i--) run_period(p[i], pos, -1, tag);
  endtask

  task automatic t_reset_state();
    do_reset();
    idx_cycles = 0;
    run_period(0, -1, -1, "R1 idle after reset");
    run_period(0, -1, -1, "R2 cadence");
    chk_int(idx_cycles, 0, "R1 no pulse after reset");
  endtask

  task automatic t_pattern_hit();
    idx_cycles = 0;
    send_pattern(PAT, 3, "R5 pattern mid-period");
    run_period(0, -1, -1, "R6 wait edge");
    run_period(0, -1, -1, "R6 pulse period");
    run_period(0, -1, -1, "R6 after pulse");
    chk_int(idx_cycles, 8, "R6 pulse length");
  endtask

  task automatic t_strobe_peak();
    idx_cycles = 0;
    run_period(0, -1, -1, "R3 pad");
    send_pattern(PAT, 7, "R3 peak in strobe cycle");
    run_period(0, -1, -1, "R3 wait");
    run_period(0, -1, -1, "R3 pulse");
    chk_int(idx_cycles, 8, "R3 strobe-cycle peaks counted");
  endtask

  task automatic t_multi_peak();
    idx_cycles = 0;
    for (int i = 5; i >= 0; i--) run_period(PAT[i], 0, 5, "R3 two peaks per period");
    run_period(0, -1, -1, "R3 wait");
    run_period(0, -1, -1, "R3 pulse");
    chk_int(idx_cycles, 8, "R3 multiple peaks give one bit");
  endtask

  task automatic t_no_carry();
    // ones placed late so a held latch would corrupt the following zero
    idx_cycles = 0;
    run_period(0, -1, -1, "R4 pad");
    send_pattern(PAT, 6, "R4 late peaks");
    run_period(0, -1, -1, "R4 wait");
    run_period(0, -1, -1, "R4 pulse");
    chk_int(idx_cycles, 8, "R4 latch cleared each period");
  endtask

  task automatic t_guard_block();
    idx_cycles = 0;
    run_period(1, 2, -1, "R7 guard one");
    send_pattern(PAT, 2, "R7 pattern after guard one");
    run_period(0, -1, -1, "R7 wait");
    run_period(0, -1, -1, "R7 quiet");
    chk_int(idx_cycles, 0, "R7 guard blocks pulse");
  endtask

  task automatic t_near_miss();
    idx_cycles = 0;
    run_period(0, -1, -1, "R7 pad");
    send_pattern(PAT ^ 6'b000001, 1, "R7 newest bit wrong");
    send_pattern(PAT ^ 6'b100000, 1, "R7 oldest bit wrong");
    run_period(0, -1, -1, "R7 wait");
    run_period(0, -1, -1, "R7 quiet");
    chk_int(idx_cycles, 0, "R7 near miss no pulse");
  endtask

  task automatic t_reset_mid_pulse();
    run_period(0, -1, -1, "R1 pad");
    send_pattern(PAT, 4, "R1 pattern before reset");
    run_period(0, -1, -1, "R1 wait");
    #1;
    chk(index, 1'b1, "R6 pulse high before reset");
    do_reset();
    idx_cycles = 0;
    run_period(0, -1, -1, "R1 after mid reset");
    run_period(0, -1, -1, "R1 after mid reset");
    chk_int(idx_cycles, 0, "R1 reset clears pulse and register");
  endtask

  initial begin
    t_reset_state();
    t_pattern_hit();
    t_strobe_peak();
    t_multi_peak();
    t_no_carry();
    t_guard_block();
    t_near_miss();
    t_reset_mid_pulse();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule